// File: doc/BRIEF.md
# Packed Narrow-Register Word Decoder

This block sits between a bus front end and a region of control registers that are narrower than the bus word. An example is 8-bit registers on a 32-bit bus. The registers are packed tightly, so several of them share one bus word.

Each access carries a byte address that is aligned to the bus word. The block turns that address into one strobe per register. Every register that lives inside the addressed word is strobed at the same time. Each register also gets its own slice of the bus write data.

For reads, the block collects the current values of the registers in the addressed word into one bus-wide word. It packs them in little-endian lane order and returns that word with an acknowledge on the next cycle. Lanes that no register occupies read as zero. An address beyond the region still gets an acknowledge, with all-zero data.

Register storage, field behaviour and byte-granular writes belong to the neighbouring logic, not to this block.

Top module: `packed_reg_decode`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `rdAck` is 0 and `rdData` is 0.
- R2: In the cycle of a request, `regStrb[i]` is 1 exactly when the request is valid and the register `i` lies in the addressed bus word. Register `i` lies in word `i / LANES`, where `LANES = BUS_W / REG_W`. All registers of that word are strobed together, and no other register is strobed.
- R3: Register `i` receives write data `regWrData[i*REG_W +: REG_W] = reqWrData[(i % LANES)*REG_W +: REG_W]`. With 8-bit registers, the register at byte offset k inside the word takes bits [8k+7:8k]. `regWrite` is 1 exactly when a valid write hits a mapped word.
- R4: `rdAck` is 1 in the cycle after a valid read request (`reqWrite` = 0). It is 0 after a write request or an idle cycle.
- R5: With `rdAck`, lane k of `rdData` (bits [k*REG_W +: REG_W]) holds the value that register `word*LANES + k` presented on `regRdData` in the request cycle. Lane 0 is the least significant, which is little-endian order.
- R6: Lanes of a mapped word that hold no register, such as the tail of a partly filled last word, read as zero.
- R7: A request to a word index of `NUM_WORDS` or more asserts no strobe and no `regWrite`. A read to such an address is still acknowledged, with `rdData` equal to zero.
- R8: Address bits below the bus-word alignment, `reqAddr[1:0]` for a 32-bit bus, have no effect on strobes or on read data.
- R9: In every cycle where `rdAck` is 0, `rdData` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request this cycle |
| reqWrite | input | 1 | 1 for a write, 0 for a read |
| reqAddr | input | ADDR_W | Byte address relative to the region base |
| reqWrData | input | BUS_W | Bus write data |
| regRdData | input | NUM_REGS*REG_W | Current value of every register, register i at [i*REG_W +: REG_W] |
| regStrb | output | NUM_REGS | Per-register access strobe |
| regWrite | output | 1 | Current strobes are a write |
| regWrData | output | NUM_REGS*REG_W | Per-register write data slices |
| rdAck | output | 1 | Read acknowledge, one cycle after a read request |
| rdData | output | BUS_W | Packed read word, valid with rdAck |

## Verification
A wrong word-index or lane-index computation shows up in the request cycle itself, as a missing or extra strobe or a write slice taken from the wrong lane.

A fault in the readback stage shows up one cycle later, in `rdData`. The symptoms are a value in the wrong byte lane, stale data, a nonzero unused lane, or nonzero data on an unmapped or idle cycle.

The bench feeds fresh random register values before every access, so any lane mix-up changes the observed word. It also sweeps every word index, including the partial last word and unmapped words, with random offset bits below the alignment.

// File: rtl/packed_reg_pkg.sv
package packed_reg_pkg;

  // Strobes passed from decode control to the datapath
  typedef struct packed {
    logic accessHit;  // valid request to a mapped word
    logic isWrite;    // request direction
    logic rdCapture;  // valid read request, load the read word
  } ctlStrobes_t;

endpackage

// File: rtl/packed_reg_ctrl.sv
module packed_reg_ctrl
  import packed_reg_pkg::*;
#(
  parameter int WORD_IDX_W = 4,
  parameter int NUM_WORDS  = 4
) (
  input  logic                  reqValid,
  input  logic                  reqWrite,
  input  logic [WORD_IDX_W-1:0] wordIdx,
  output ctlStrobes_t           ctl
);

  localparam logic [WORD_IDX_W:0] WORDS_LIM = (WORD_IDX_W+1)'(NUM_WORDS);

  logic wordMapped;

  assign wordMapped = ({1'b0, wordIdx} < WORDS_LIM);

  always_comb begin
    ctl.accessHit = reqValid && wordMapped;
    ctl.isWrite   = reqWrite;
    ctl.rdCapture = reqValid && !reqWrite;
  end

endmodule

// File: rtl/packed_reg_datapath.sv
module packed_reg_datapath
  import packed_reg_pkg::*;
#(
  parameter int BUS_W      = 32,
  parameter int REG_W      = 8,
  parameter int NUM_REGS   = 14,
  parameter int WORD_IDX_W = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctlStrobes_t               ctl,
  input  logic [WORD_IDX_W-1:0]     wordIdx,
  input  logic [BUS_W-1:0]          reqWrData,
  input  logic [NUM_REGS*REG_W-1:0] regRdData,
  output logic [NUM_REGS-1:0]       regStrb,
  output logic                      regWrite,
  output logic [NUM_REGS*REG_W-1:0] regWrData,
  output logic                      rdAck,
  output logic [BUS_W-1:0]          rdData
);

  localparam int LANES = BUS_W / REG_W;

  logic [BUS_W-1:0] packedWord;

  // Per-register strobe and write slice
  for (genvar i = 0; i < NUM_REGS; i++) begin : gRegLane
    localparam int WORD_NUM = i / LANES;
    localparam int LANE_NUM = i % LANES;
    assign regStrb[i] = ctl.accessHit && (wordIdx == WORD_IDX_W'(WORD_NUM));
    assign regWrData[i*REG_W +: REG_W] = reqWrData[LANE_NUM*REG_W +: REG_W];
  end

  assign regWrite = ctl.accessHit && ctl.isWrite;

  // Readback: place each register of the addressed word into its lane
  always_comb begin
    packedWord = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (ctl.accessHit && (wordIdx == WORD_IDX_W'(i / LANES))) begin
        packedWord[(i % LANES)*REG_W +: REG_W] = regRdData[i*REG_W +: REG_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdAck  <= 1'b0;
      rdData <= '0;
    end else begin
      rdAck  <= ctl.rdCapture;
      rdData <= ctl.rdCapture ? packedWord : '0;
    end
  end

endmodule

// File: rtl/packed_reg_decode.sv
module packed_reg_decode
  import packed_reg_pkg::*;
#(
  parameter int BUS_W    = 32,
  parameter int REG_W    = 8,
  parameter int NUM_REGS = 14,
  parameter int ADDR_W   = 6
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  input  logic                      reqWrite,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  logic [BUS_W-1:0]          reqWrData,
  input  logic [NUM_REGS*REG_W-1:0] regRdData,
  output logic [NUM_REGS-1:0]       regStrb,
  output logic                      regWrite,
  output logic [NUM_REGS*REG_W-1:0] regWrData,
  output logic                      rdAck,
  output logic [BUS_W-1:0]          rdData
);

  localparam int LANES      = BUS_W / REG_W;
  localparam int NUM_WORDS  = (NUM_REGS + LANES - 1) / LANES;
  localparam int BYTE_OFF_W = $clog2(BUS_W / 8);
  localparam int WORD_IDX_W = ADDR_W - BYTE_OFF_W;

  ctlStrobes_t           ctl;
  logic [WORD_IDX_W-1:0] wordIdx;
  logic                  unusedOffset;

  // Offset bits inside the bus word are dropped: the address is word-aligned
  assign wordIdx      = reqAddr[ADDR_W-1:BYTE_OFF_W];
  assign unusedOffset = ^reqAddr[BYTE_OFF_W-1:0];

  packed_reg_ctrl #(
    .WORD_IDX_W(WORD_IDX_W),
    .NUM_WORDS (NUM_WORDS)
  ) u_ctrl (
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .wordIdx (wordIdx),
    .ctl     (ctl)
  );

  packed_reg_datapath #(
    .BUS_W     (BUS_W),
    .REG_W     (REG_W),
    .NUM_REGS  (NUM_REGS),
    .WORD_IDX_W(WORD_IDX_W)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .wordIdx  (wordIdx),
    .reqWrData(reqWrData),
    .regRdData(regRdData),
    .regStrb  (regStrb),
    .regWrite (regWrite),
    .regWrData(regWrData),
    .rdAck    (rdAck),
    .rdData   (rdData)
  );

endmodule

// File: rtl/packed_reg_decode_chk.sv
module packed_reg_decode_chk #(
  parameter int BUS_W    = 32,
  parameter int REG_W    = 8,
  parameter int NUM_REGS = 14,
  parameter int ADDR_W   = 6
) (
  input logic                clk,
  input logic                rstN,
  input logic                reqValid,
  input logic                reqWrite,
  input logic [NUM_REGS-1:0] regStrb,
  input logic                regWrite,
  input logic                rdAck,
  input logic [BUS_W-1:0]    rdData
);

  localparam int LANES = BUS_W / REG_W;

  AST_STRB_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (|regStrb) |-> reqValid);  // R2

  AST_STRB_ONE_WORD: assert property (@(posedge clk) disable iff (!rstN)
    $countones(regStrb) <= LANES);  // R2

  AST_WRITE_HAS_STRB: assert property (@(posedge clk) disable iff (!rstN)
    regWrite |-> ((|regStrb) && reqWrite));  // R3

  AST_ACK_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite) |=> rdAck);  // R4

  AST_NO_ACK_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite) |=> !rdAck);  // R4

  AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !rdAck |-> (rdData == '0));  // R9

endmodule

bind packed_reg_decode packed_reg_decode_chk #(
  .BUS_W   (BUS_W),
  .REG_W   (REG_W),
  .NUM_REGS(NUM_REGS),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqValid(reqValid),
  .reqWrite(reqWrite),
  .regStrb (regStrb),
  .regWrite(regWrite),
  .rdAck   (rdAck),
  .rdData  (rdData)
);

// File: tb/packed_reg_decode_bench.sv
`timescale 1ns/1ps
module packed_reg_decode_bench;

  localparam int BUS_W     = 32;
  localparam int REG_W     = 8;
  localparam int NUM_REGS  = 14;
  localparam int ADDR_W    = 6;
  localparam int LANES     = BUS_W / REG_W;
  localparam int NUM_WORDS = (NUM_REGS + LANES - 1) / LANES;

  logic                      clk = 1'b0;
  logic                      rstN = 1'b0;
  logic                      reqValid = 1'b0;
  logic                      reqWrite = 1'b0;
  logic [ADDR_W-1:0]         reqAddr = '0;
  logic [BUS_W-1:0]          reqWrData = '0;
  logic [NUM_REGS*REG_W-1:0] regRdData = '0;
  logic [NUM_REGS-1:0]       regStrb;
  logic                      regWrite;
  logic [NUM_REGS*REG_W-1:0] regWrData;
  logic                      rdAck;
  logic [BUS_W-1:0]          rdData;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  packed_reg_decode #(
    .BUS_W(BUS_W), .REG_W(REG_W), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)
  ) u_packed_reg_decode (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWrData(reqWrData), .regRdData(regRdData),
    .regStrb(regStrb), .regWrite(regWrite), .regWrData(regWrData),
    .rdAck(rdAck), .rdData(rdData)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NUM_REGS-1:0] expStrb(input logic [ADDR_W-1:0] a);
    logic [NUM_REGS-1:0] s = '0;
    for (int i = 0; i < NUM_REGS; i++) s[i] = ((int'(a) >> 2) == i / LANES);
    return s;
  endfunction

  function automatic logic [BUS_W-1:0] expWord(input logic [ADDR_W-1:0] a,
                                               input logic [NUM_REGS*REG_W-1:0] r);
    logic [BUS_W-1:0] w = '0;
    int word = int'(a) >> 2;
    for (int k = 0; k < LANES; k++) begin
      int idx = word * LANES + k;
      if (word < NUM_WORDS && idx < NUM_REGS) w[k*REG_W +: REG_W] = r[idx*REG_W +: REG_W];
    end
    return w;
  endfunction

  function automatic logic [NUM_REGS*REG_W-1:0] expSlices(input logic [BUS_W-1:0] d);
    logic [NUM_REGS*REG_W-1:0] s;
    for (int i = 0; i < NUM_REGS; i++) s[i*REG_W +: REG_W] = d[(i % LANES)*REG_W +: REG_W];
    return s;
  endfunction

  task automatic randomRegs();
    for (int i = 0; i < NUM_REGS; i++) regRdData[i*REG_W +: REG_W] = REG_W'($urandom);
  endtask

  // One access: strobes checked in the request cycle, read result one cycle later
  task automatic access(input logic [ADDR_W-1:0] a, input logic wr, input logic [BUS_W-1:0] d);
    logic [BUS_W-1:0] expRd;
    @(negedge clk);
    randomRegs();
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWrData = d;
    #2;
    check("R2/R7 strobes", 128'(regStrb), 128'(expStrb(a)));
    check("R3 regWrite", 128'(regWrite), 128'(wr && ((int'(a) >> 2) < NUM_WORDS)));
    check("R3 write slices", 128'(regWrData), 128'(expSlices(d)));
    expRd = expWord(a, regRdData);
    @(negedge clk);
    reqValid = 1'b0;
    randomRegs();
    check("R4 rdAck", 128'(rdAck), 128'(!wr));
    check("R5/R6/R7 rdData", 128'(rdData), wr ? 128'(0) : 128'(expRd));
  endtask

  task automatic idleCheck();
    @(negedge clk);
    #2;
    check("R2 no strobe idle", 128'(regStrb), 128'(0));
    @(negedge clk);
    check("R4 no ack after idle", 128'(rdAck), 128'(0));
    check("R9 idle data zero", 128'(rdData), 128'(0));
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check("R1 rdAck in reset", 128'(rdAck), 128'(0));
    check("R1 rdData in reset", 128'(rdData), 128'(0));
    rstN = 1'b1;
    @(negedge clk);
    check("R1 rdAck after reset", 128'(rdAck), 128'(0));
    check("R1 rdData after reset", 128'(rdData), 128'(0));

    // Directed: every word, read and write, incl. partial last word (R6)
    for (int w = 0; w < 16; w++) begin
      access(ADDR_W'(w * 4), 1'b0, '0);
      access(ADDR_W'(w * 4), 1'b1, $urandom);
    end
    // R8: offset bits ignored, same word under all low-bit patterns
    for (int lo = 0; lo < 4; lo++) access(ADDR_W'(12 + lo), 1'b0, '0);
    // R7: unmapped reads return acknowledged zero
    access(ADDR_W'(60), 1'b0, '0);
    idleCheck();
    // R9 back to back then idle
    access(ADDR_W'(4), 1'b0, '0);
    idleCheck();

    // Constrained random mix
    for (int n = 0; n < 300; n++) begin
      access(ADDR_W'($urandom), 1'($urandom), $urandom);
      if (($urandom % 8) == 0) idleCheck();
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule